// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a stream of oscillator-side input events by a programmable ratio N with the pulse-swallow method. Each input event arrives as a one-cycle clock enable. A dual-modulus prescaler counts these events and divides by 33 or by 32. A 5-bit swallow counter picks the modulus, and a main counter counts whole prescaler periods. Once N enabled inputs have been counted, the block emits one comparison pulse for the phase detector and starts the next division cycle.

N splits into two fields. The low 5 bits are the swallow count S, and the bits above them are the main count M, so N = 32·M + S. During the first S prescaler periods of a cycle the prescaler divides by 33. It then divides by 32 for the remaining M − S periods. A width mode picks an 11-bit main counter (16-bit N) or a 13-bit main counter (18-bit N). A load strobe writes a new N into a holding register. The divider only copies that value into its counters when a new division cycle begins, so a change never cuts a cycle short.

Top module: `pswallow_div`

## Requirements
- R1: After reset `pulse_o` and `mod33_o` are 0, and the divider runs in the 16-bit mode with N = 1056. The first pulse follows the 1056th enabled input.
- R2: For a programmed N, `pulse_o` goes high for exactly one clock cycle, in the cycle after the clock edge that accepted the N-th enabled input of the division cycle. The next division cycle starts on that same edge.
- R3: A clock cycle with `fin_en` = 0 advances no counter and produces no pulse. The pulse period therefore counts enabled inputs, not clock cycles.
- R4: The swallow count S is `n_val[4:0]`, and the main count M is the bits from bit 5 upward. `mod33_o` is 1 for exactly the first 33·S enabled inputs of a division cycle and 0 for the rest of that cycle.
- R5: When `load` is sampled with `wide_mode` = 0 (16-bit mode), only `n_val[15:0]` is used and bits 17:16 are ignored. The usable range runs up to 65535.
- R6: When `load` is sampled with `wide_mode` = 1 (18-bit mode), all 18 bits of `n_val` are used. The usable range runs up to 262143.
- R7: A loaded N below 1056 is replaced by 1056. This keeps the main count at 33 or more, so it is never below the swallow count.
- R8: A value loaded partway through a division cycle does not change that cycle. It takes effect from the next division cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fin_en | input | 1 | One enabled input event from the oscillator side |
| n_val | input | 18 | Requested division ratio |
| wide_mode | input | 1 | 1 selects the 18-bit mode, 0 the 16-bit mode; sampled with `load` |
| load | input | 1 | Strobe that writes `n_val` into the holding register |
| pulse_o | output | 1 | One-cycle comparison pulse, once per N enabled inputs |
| mod33_o | output | 1 | 1 while the prescaler divides by 33 |

## Verification
The case hardest to reach from the ports is a reload that lands inside a cycle that is already running. In that case the old ratio must finish while the new one waits in the holding register. Each directed scenario therefore issues its load partway through the measured period and checks that this period still matches the previous ratio. The following scenario then checks the new ratio. Swallow handling is observed at the ports by counting the enabled inputs for which `mod33_o` is high. This is done for swallow counts of 0, 12, 16 and 31, and in one scenario the enables are gapped.

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int SW_W     = 5,
  parameter int MAIN_W_N = 11,
  parameter int MAIN_W_W = 13,
  parameter int N_MIN    = 1056
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fin_en,
  input  logic [SW_W+MAIN_W_W-1:0] n_val,
  input  logic                     wide_mode,
  input  logic                     load,
  output logic                     pulse_o,
  output logic                     mod33_o
);
  localparam int NW     = SW_W + MAIN_W_W;
  localparam int NW_N   = SW_W + MAIN_W_N;
  localparam int PRE_W  = SW_W + 1;
  localparam int PRE_LO = 1 << SW_W;
  localparam logic [NW-1:0] MASK_N = NW'((1 << NW_N) - 1);
  localparam logic [NW-1:0] N_DEF  = NW'(N_MIN);

  logic [NW-1:0]       n_masked, n_eff;
  logic [MAIN_W_W-1:0] pend_main, main_cnt;
  logic [SW_W-1:0]     pend_sw, sw_cnt;
  logic [PRE_W-1:0]    pre_cnt;
  logic                pre_last, cyc_end;

  assign n_masked = wide_mode ? n_val : (n_val & MASK_N);
  assign n_eff    = (n_masked < N_DEF) ? N_DEF : n_masked;
  assign mod33_o  = (sw_cnt != '0);
  assign pre_last = (pre_cnt == (mod33_o ? PRE_W'(PRE_LO) : PRE_W'(PRE_LO - 1)));
  assign cyc_end  = fin_en && pre_last && (main_cnt == MAIN_W_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_main <= N_DEF[NW-1:SW_W];
      pend_sw   <= N_DEF[SW_W-1:0];
    end else if (load) begin
      pend_main <= n_eff[NW-1:SW_W];
      pend_sw   <= n_eff[SW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      sw_cnt   <= N_DEF[SW_W-1:0];
      main_cnt <= N_DEF[NW-1:SW_W];
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= cyc_end;
      if (fin_en) begin
        if (!pre_last) begin
          pre_cnt <= pre_cnt + 1'b1;
        end else begin
          pre_cnt <= '0;
          if (cyc_end) begin
            sw_cnt   <= pend_sw;
            main_cnt <= pend_main;
          end else begin
            main_cnt <= main_cnt - 1'b1;
            if (mod33_o) sw_cnt <= sw_cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

module pswallow_div_chk #(
  parameter int SW_W     = 5,
  parameter int MAIN_W_N = 11,
  parameter int MAIN_W_W = 13,
  parameter int N_MIN    = 1056
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fin_en,
  input logic                wide_mode,
  input logic                load,
  input logic                pulse_o,
  input logic                mod33_o,
  input logic [SW_W:0]       pre_cnt,
  input logic [MAIN_W_W-1:0] pend_main,
  input logic [MAIN_W_W-1:0] main_cnt
);
  localparam int MAIN_MIN = N_MIN / (1 << SW_W);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_en |=> $stable(pre_cnt) && $stable(main_cnt) && !pulse_o);

  // R4
  mod33_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod33_o) |-> pulse_o);

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= (SW_W+1)'(1 << SW_W));

  // R5
  narrow_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !wide_mode |=> pend_main < MAIN_W_W'(1 << MAIN_W_N));

  // R7
  clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_main >= MAIN_W_W'(MAIN_MIN));
endmodule

bind pswallow_div pswallow_div_chk #(
  .SW_W(SW_W), .MAIN_W_N(MAIN_W_N), .MAIN_W_W(MAIN_W_W), .N_MIN(N_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fin_en(fin_en), .wide_mode(wide_mode),
  .load(load), .pulse_o(pulse_o), .mod33_o(mod33_o), .pre_cnt(pre_cnt),
  .pend_main(pend_main), .main_cnt(main_cnt)
);

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fin_en = 1'b0;
  logic [17:0] n_val = '0;
  logic        wide_mode = 1'b0;
  logic        load = 1'b0;
  logic        pulse_o, mod33_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pswallow_div dut_i (
    .clk(clk), .rst_n(rst_n), .fin_en(fin_en), .n_val(n_val),
    .wide_mode(wide_mode), .load(load), .pulse_o(pulse_o), .mod33_o(mod33_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measures one division period from the current negedge (just after a pulse or reset).
  task automatic period(input string req, input int exp_n, input int exp_m33, input bit gap,
                        input int load_at, input int ld_n, input bit ld_w);
    int c = 0;
    int m = 0;
    int clk_n = 0;
    bit done = 0;
    bit first = 1;
    while (!done && clk_n < 180000) begin
      fin_en = gap ? clk_n[0] : 1'b1;
      if (c == load_at && fin_en) begin
        n_val = 18'(ld_n); wide_mode = ld_w; load = 1'b1;
      end
      if (fin_en) begin
        c++;
        if (mod33_o) m++;
      end
      clk_n++;
      @(negedge clk);
      load = 1'b0;
      if (first) begin
        chk("R2 pulse width", int'(pulse_o), 0);
        first = 0;
      end else if (pulse_o) done = 1;
    end
    fin_en = 1'b0;
    chk({req, " period"}, c, exp_n);
    chk("R4 mod33 span", m, exp_m33);
    if (gap) chk("R3 clocks per period", clk_n, 2 * exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", int'(pulse_o), 0);
    chk("R1 mod33 in reset", int'(mod33_o), 0);
    rst_n = 1'b1;
    // R1 default 1056; R8 load 1100 mid-cycle must not alter this cycle
    period("R1/R8 default", 1056, 0, 0, 500, 1100, 0);
    // R4: 1100 = 34*32+12
    period("R4/R8 ratio 1100", 1100, 396, 0, 300, 1000, 0);
    // R7: 1000 clamps to 1056
    period("R7 clamp", 1056, 0, 0, 200, 1100, 0);
    // R3: gapped enables, 16-bit load of 70000 -> 4464 (bits 17:16 dropped)
    period("R3 gapped", 1100, 396, 1, 400, 70000, 0);
    // R5: 4464 = 139*32+16
    period("R5 masked", 4464, 528, 0, 1000, 65535, 0);
    // R5 top of 16-bit range: S=31
    period("R5 max16", 65535, 1023, 0, 2000, 70000, 1);
    // R6: 70000 = 2187*32+16 in 18-bit mode
    period("R6 wide", 70000, 528, 0, -1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<195000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule